// File: doc/BRIEF.md
# Destination Address Filter

This block sits at the front of a receive path and decides, for every incoming frame, whether the frame is meant for this station. It sees the received bytes one at a time, with a valid strobe and a start-of-frame strobe. It looks at the first six bytes after the start of frame, which hold the destination address. From those bytes it builds a physical compare against a programmed 48-bit station address, an all-ones check and a 6-bit hash. The hash picks one bit of a 64-bit multicast filter.

One clock after the sixth address byte has been taken, the block reports a decision. The decision carries accept or reject and the address class: physical, multicast or broadcast. On a reject it pulses a flush signal, so the receive buffer can throw away what it has already stored for that frame. Each kind of acceptance has its own enable, and a promiscuous enable accepts every frame.

The station address, the filter bits and the enables are sampled on the clock edge that takes the sixth byte. A new start of frame at any point drops the frame in progress and clears the earlier decision.

Top module: `dst_addr_filter`

## Requirements
- R1: Only the first six bytes taken after a start of frame form the address. Bytes taken after the sixth, and bytes taken before any start of frame since reset, change no output.
- R2: `dec_vld` is high for exactly one cycle. That cycle follows the clock edge on which the sixth address byte was taken. Idle cycles with `rx_vld` low may come between address bytes.
- R3: The group bit is bit 0 of the first address byte. `addr_kind` reports 2'd2 when all 48 address bits are one, otherwise 2'd1 when the group bit is set, and 2'd0 when it is clear.
- R4: A physical address is accepted only when `en_phys` is set and every address byte i equals `station_addr[8*i+7:8*i]`.
- R5: An all-ones address is accepted when `en_bcast` is set. It is never accepted through the multicast filter.
- R6: For a multicast address that is not all ones, the hash works as follows. A 32-bit register starts at all ones. The six bytes are shifted in least significant bit first. On each bit, the register shifts right and is XORed with 0xEDB88320 when (register bit 0 XOR data bit) is 1. The index is bits [31:26] of the result. The frame is accepted only if `en_mcast` is set and `mcast_filter[index]` is 1.
- R7: When `en_promisc` is set, every frame is accepted, and `addr_kind` still reports the class.
- R8: `flush` pulses in the decision cycle if, and only if, the frame is rejected.
- R9: A start of frame clears `accept` and sets `addr_kind` to 2'd0 on the next edge. It also restarts address collection, and a byte presented with the same strobe counts as the first address byte.
- R10: After reset, `dec_vld`, `accept`, `flush` and `addr_kind` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe |
| rx_vld | input | 1 | Received byte is valid this cycle |
| rx_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| mcast_filter | input | 64 | Multicast filter bits, indexed by hash |
| en_phys | input | 1 | Enable physical match acceptance |
| en_bcast | input | 1 | Enable broadcast acceptance |
| en_mcast | input | 1 | Enable multicast hash acceptance |
| en_promisc | input | 1 | Accept every frame |
| dec_vld | output | 1 | Decision strobe, one cycle |
| accept | output | 1 | Frame accepted, held until next start of frame |
| flush | output | 1 | Reject pulse that clears receive storage |
| addr_kind | output | 2 | 0 physical, 1 multicast, 2 broadcast |

## Verification
The assertions assume that `rx_sof` and `rx_vld` are synchronous and free of X. They also assume that the configuration inputs are stable at the edge that takes the sixth byte. The stimulus meets this by driving every input just after the falling edge. It changes the station address, the filter and the enables only between frames. The timing properties rely on at least five byte-taking edges between two decisions, and the frame-level stimulus guarantees this.

// File: rtl/daf_pkg.sv
package daf_pkg;
  typedef enum logic [1:0] {
    KIND_PHYS  = 2'd0,
    KIND_MCAST = 2'd1,
    KIND_BCAST = 2'd2
  } addr_kind_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
endpackage

// File: rtl/daf_crc_step.sv
module daf_crc_step #(
  parameter int DATA_W = 8
) (
  input  logic [31:0]       crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [31:0]       crc_out
);
  import daf_pkg::*;

  // Serial reflected update, LSB of the data first
  always_comb begin
    logic [31:0] acc;
    acc = crc_in;
    for (int b = 0; b < DATA_W; b++) begin
      if (acc[0] ^ data_in[b]) acc = (acc >> 1) ^ CRC_POLY_REFL;
      else                     acc = acc >> 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/daf_addr_track.sv
module daf_addr_track #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_sof,
  input  logic                    rx_vld,
  input  logic [7:0]              rx_byte,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    last_take,
  output logic                    match_fin,
  output logic                    ones_fin,
  output logic                    group_fin,
  output logic [HASH_W-1:0]       hash_fin
);
  import daf_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic [31:0]      crc_q, crc_d, crc_eff, crc_upd;
  logic             match_q, match_d, match_eff;
  logic             ones_q, ones_d, ones_eff;
  logic             grp_q, grp_d;
  logic             take;
  logic [7:0]       stn_byte;

  // A start of frame overrides the held state in the same cycle
  assign cnt_eff   = rx_sof ? '0 : cnt_q;
  assign crc_eff   = rx_sof ? CRC_SEED : crc_q;
  assign match_eff = rx_sof | match_q;
  assign ones_eff  = rx_sof | ones_q;
  assign take      = rx_vld && (cnt_eff < CNT_W'(ADDR_BYTES));

  always_comb begin
    stn_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_eff == CNT_W'(i)) stn_byte = station_addr[8*i +: 8];
  end

  daf_crc_step #(.DATA_W(8)) u_crc (
    .crc_in (crc_eff),
    .data_in(rx_byte),
    .crc_out(crc_upd)
  );

  always_comb begin
    cnt_d   = cnt_eff;
    crc_d   = crc_eff;
    match_d = match_eff;
    ones_d  = ones_eff;
    grp_d   = rx_sof ? 1'b0 : grp_q;
    if (take) begin
      cnt_d   = cnt_eff + 1'b1;
      crc_d   = crc_upd;
      match_d = match_eff & (rx_byte == stn_byte);
      ones_d  = ones_eff & (&rx_byte);
      if (cnt_eff == '0) grp_d = rx_byte[0];
    end
  end

  assign last_take = take && (cnt_eff == CNT_W'(ADDR_BYTES - 1));
  assign match_fin = match_d;
  assign ones_fin  = ones_d;
  assign group_fin = (ADDR_BYTES == 1) ? rx_byte[0] : grp_q;
  assign hash_fin  = crc_d[31 -: HASH_W];

  // Idle after reset: counter parked at the end, nothing collected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(ADDR_BYTES);
      crc_q   <= CRC_SEED;
      match_q <= 1'b0;
      ones_q  <= 1'b0;
      grp_q   <= 1'b0;
    end else if (rx_sof || take) begin
      cnt_q   <= cnt_d;
      crc_q   <= crc_d;
      match_q <= match_d;
      ones_q  <= ones_d;
      grp_q   <= grp_d;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  assert_no_take_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_sof && cnt_q == CNT_W'(ADDR_BYTES)) |=> $stable(crc_q));
endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int HASH_W    = 6,
  localparam int FILT_W   = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic              last_take,
  input  logic              match_fin,
  input  logic              ones_fin,
  input  logic              group_fin,
  input  logic [HASH_W-1:0] hash_fin,
  input  logic [FILT_W-1:0] mcast_filter,
  input  logic              en_phys,
  input  logic              en_bcast,
  input  logic              en_mcast,
  input  logic              en_promisc,
  output logic              dec_vld,
  output logic              accept,
  output logic              flush,
  output logic [1:0]        addr_kind
);
  import daf_pkg::*;

  addr_kind_e kind_d, kind_q;
  logic       acc_d, acc_q, vld_q, flush_q;
  logic       upd_en;

  assign upd_en = last_take | rx_sof;

  always_comb begin
    kind_d = KIND_PHYS;
    acc_d  = 1'b0;
    if (last_take) begin
      if (ones_fin)       kind_d = KIND_BCAST;
      else if (group_fin) kind_d = KIND_MCAST;
      else                kind_d = KIND_PHYS;
      unique case (kind_d)
        KIND_BCAST: acc_d = en_bcast;
        KIND_MCAST: acc_d = en_mcast & mcast_filter[hash_fin];
        default:    acc_d = en_phys & match_fin;
      endcase
      acc_d = acc_d | en_promisc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      flush_q <= 1'b0;
      acc_q   <= 1'b0;
      kind_q  <= KIND_PHYS;
    end else begin
      vld_q   <= last_take;
      flush_q <= last_take & ~acc_d;
      if (upd_en) begin
        acc_q  <= acc_d;
        kind_q <= kind_d;
      end
    end
  end

  assign dec_vld   = vld_q;
  assign accept    = acc_q;
  assign flush     = flush_q;
  assign addr_kind = kind_q;

  assert_flush_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (dec_vld && !accept));

  assert_reject_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !accept) |-> flush);

  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && en_promisc) |=> accept);

  assert_sof_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && !last_take) |=> (!accept && addr_kind == 2'd0));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int FILT_W    = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [FILT_W-1:0] mcast_filter,
  input  logic              en_phys,
  input  logic              en_bcast,
  input  logic              en_mcast,
  input  logic              en_promisc,
  output logic              dec_vld,
  output logic              accept,
  output logic              flush,
  output logic [1:0]        addr_kind
);
  logic              last_take, match_fin, ones_fin, group_fin;
  logic [HASH_W-1:0] hash_fin;

  daf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_sof      (rx_sof),
    .rx_vld      (rx_vld),
    .rx_byte     (rx_byte),
    .station_addr(station_addr),
    .last_take   (last_take),
    .match_fin   (match_fin),
    .ones_fin    (ones_fin),
    .group_fin   (group_fin),
    .hash_fin    (hash_fin)
  );

  daf_decide #(.HASH_W(HASH_W)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_sof      (rx_sof),
    .last_take   (last_take),
    .match_fin   (match_fin),
    .ones_fin    (ones_fin),
    .group_fin   (group_fin),
    .hash_fin    (hash_fin),
    .mcast_filter(mcast_filter),
    .en_phys     (en_phys),
    .en_bcast    (en_bcast),
    .en_mcast    (en_mcast),
    .en_promisc  (en_promisc),
    .dec_vld     (dec_vld),
    .accept      (accept),
    .flush       (flush),
    .addr_kind   (addr_kind)
  );

  assert_decision_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> dec_vld);

  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_kind != 2'd3);
endmodule

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_sof, rx_vld;
  logic [7:0]  rx_byte;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;
  logic        en_phys, en_bcast, en_mcast, en_promisc;
  logic        dec_vld, accept, flush;
  logic [1:0]  addr_kind;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  dst_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .station_addr(station_addr), .mcast_filter(mcast_filter),
    .en_phys(en_phys), .en_bcast(en_bcast), .en_mcast(en_mcast), .en_promisc(en_promisc),
    .dec_vld(dec_vld), .accept(accept), .flush(flush), .addr_kind(addr_kind)
  );

  // Hash index from the requirement text, bit by bit
  function automatic int hash_of(input logic [7:0] a [6]);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ a[i][b];
        r = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    return int'(r[31:26]);
  endfunction

  // Behavioural reference model
  int         m_n;
  logic [7:0] m_buf [6];
  logic       m_vld, m_acc, m_flush;
  logic [1:0] m_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 6; m_vld = 0; m_acc = 0; m_flush = 0; m_kind = 0;
    end else begin
      m_vld = 0; m_flush = 0;
      if (rx_sof) begin m_n = 0; m_acc = 0; m_kind = 0; end
      if (rx_vld && m_n < 6) begin
        m_buf[m_n] = rx_byte;
        m_n++;
        if (m_n == 6) begin
          bit all1, same;
          all1 = 1; same = 1;
          for (int i = 0; i < 6; i++) begin
            if (m_buf[i] != 8'hFF) all1 = 0;
            if (m_buf[i] != station_addr[8*i +: 8]) same = 0;
          end
          if (all1) begin m_kind = 2; m_acc = en_bcast; end
          else if (m_buf[0][0]) begin m_kind = 1; m_acc = en_mcast && mcast_filter[hash_of(m_buf)]; end
          else begin m_kind = 0; m_acc = en_phys && same; end
          if (en_promisc) m_acc = 1;
          m_vld = 1;
          m_flush = !m_acc;
        end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 || rst_n === 1'b0) begin
      total++;
      if (dec_vld !== m_vld || accept !== m_acc || flush !== m_flush || addr_kind !== m_kind) begin
        bad++;
        $display("FAIL %s t=%0t: vld/acc/flush/kind actual=%b%b%b%0d expected=%b%b%b%0d",
                 cur_req, $time, dec_vld, accept, flush, addr_kind, m_vld, m_acc, m_flush, m_kind);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_sof = 0; rx_vld = 0;
    end
  endtask

  // Send n bytes, first with sof; gap inserts an idle cycle between bytes
  task automatic frame(input logic [63:0] bytes, input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_sof = (i == 0); rx_vld = 1; rx_byte = bytes[8*i +: 8];
      if (gap) begin @(negedge clk); rx_sof = 0; rx_vld = 0; end
    end
    @(negedge clk); rx_sof = 0; rx_vld = 0;
    idle(2);
  endtask

  localparam logic [47:0] STN = 48'h55_44_33_22_11_02;
  localparam logic [47:0] MC  = 48'h06_05_04_03_02_01;

  initial begin
    logic [7:0] mc_b [6];
    int hidx;
    for (int i = 0; i < 6; i++) mc_b[i] = MC[8*i +: 8];
    hidx = hash_of(mc_b);

    rst_n = 0; rx_sof = 0; rx_vld = 0; rx_byte = 0;
    station_addr = STN; mcast_filter = '0;
    en_phys = 1; en_bcast = 1; en_mcast = 1; en_promisc = 0;
    idle(3);
    cur_req = "R10"; idle(1);
    rst_n = 1;

    cur_req = "R1";  // bytes before any sof are ignored
    @(negedge clk); rx_vld = 1; rx_byte = 8'hFF; idle(8);

    cur_req = "R4"; frame({16'h0, STN}, 6, 0);
    cur_req = "R4"; frame({16'h0, STN ^ 48'h01_00_00_00_00_00}, 6, 0);
    cur_req = "R4"; en_phys = 0; frame({16'h0, STN}, 6, 0); en_phys = 1;
    cur_req = "R2"; frame({16'h0, STN}, 6, 1);
    cur_req = "R1"; frame({16'hAAAA, STN}, 8, 0);
    cur_req = "R5"; frame({16'h0, 48'hFFFF_FFFF_FFFF}, 6, 0);
    cur_req = "R5"; en_bcast = 0; mcast_filter = '1; frame({16'h0, 48'hFFFF_FFFF_FFFF}, 6, 0);
    en_bcast = 1;
    cur_req = "R6"; mcast_filter = '0; mcast_filter[hidx] = 1; frame({16'h0, MC}, 6, 0);
    cur_req = "R6"; mcast_filter = '1; mcast_filter[hidx] = 0; frame({16'h0, MC}, 6, 0);
    cur_req = "R6"; mcast_filter = '1; en_mcast = 0; frame({16'h0, MC}, 6, 1); en_mcast = 1;
    cur_req = "R3"; frame({16'h0, STN ^ 48'h00_00_00_00_00_01}, 6, 0);
    cur_req = "R7"; en_promisc = 1; en_phys = 0; en_bcast = 0; en_mcast = 0;
    frame({16'h0, 48'h12_34_56_78_9A_BC}, 6, 0);
    frame({16'h0, MC}, 6, 0);
    en_promisc = 0; en_phys = 1; en_bcast = 1; en_mcast = 1;
    cur_req = "R8"; frame({16'h0, 48'h12_34_56_78_9A_BC}, 6, 0);
    cur_req = "R9"; frame({16'h0, STN}, 6, 0);
    frame({48'h0, 16'hFFFF}, 2, 0);      // restart mid-address
    frame({16'h0, STN}, 6, 0);
    @(negedge clk); rx_sof = 1; rx_vld = 0;  // lone sof clears decision
    idle(3);
    cur_req = "R9"; frame({16'h0, STN}, 3, 0);
    frame({16'h0, STN}, 6, 0);
    idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule